// File: doc/BRIEF.md
# Tile Output Accumulation Buffer

This block holds one square tile of 32-bit results produced by a systolic matrix-multiply array. It sits behind the array and takes one full row of results per transfer. It can either replace the stored row or add the incoming row to it. A software loop that walks the inner dimension of a large product can therefore build C += A x B in place, one tile product at a time, and read the finished tile back afterwards.

Results arrive on a valid/ready stream. Each beat carries every column of one row, the row index, and an end-of-pass marker. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the sender must hold the beat unchanged. `in_ready` drops only while a clear sweep is running, and in the cycle that such a sweep is launched.

Control is done through plain pins:
- `first_tile` makes the next pass overwrite instead of add.
- `clear_req` zeroes the whole tile, one row per cycle.
- `busy` reports that the stored contents are still changing.

A host read port returns one entry, addressed by row and column, one cycle after the request. Host reads are only meaningful while `busy` is low.

Top module: `tile_acc_buffer`

## Requirements
- R1: After reset, every stored entry reads as zero, `busy` is 0, `in_ready` is 1 and `rd_valid` is 0.
- R2: A `first_tile` pulse outside a pass arms overwrite mode. Every beat of the following pass replaces the addressed row with the beat data.
- R3: Without overwrite mode, each entry of the addressed row becomes old value plus beat value, modulo 2^32, with no saturation.
- R4: A pass ends on the transferred beat that has `in_last` = 1. Overwrite mode is disarmed there, so the next pass adds unless `first_tile` is pulsed again.
- R5: A beat updates all COLS entries of row `in_row` in a single write. Column c takes `in_data[c*32 +: 32]`, and all other rows are left untouched.
- R6: A beat transfers only when `in_valid` and `in_ready` are both high. `in_ready` is low throughout a clear sweep, and the sender holds the beat until it is taken.
- R7: `clear_req`, when the buffer is not busy, starts a sweep that writes zero to rows 0 to ROWS-1, one row per cycle. `busy` is high and `in_ready` low for exactly ROWS cycles after the request edge.
- R8: `busy` is high while a pass is open, while the sweep runs, and in the cycle after the last beat of a pass, when that beat is written. It is low otherwise.
- R9: A host read with `rd_en` = 1 returns the entry at (`rd_row`, `rd_col`) on `rd_data`, with `rd_valid` = 1, one cycle later.
- R10: While a pass is open, `first_tile` and `clear_req` are ignored: the pass keeps adding and no entry is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row beat present |
| in_ready | output | 1 | Buffer can take a beat |
| in_row | input | 4 | Row index of the beat |
| in_last | input | 1 | Beat closes the current pass |
| in_data | input | 512 | COLS values of 32 bits; column c at bits c*32 and up |
| first_tile | input | 1 | Pulse: next pass overwrites |
| clear_req | input | 1 | Pulse: zero the whole tile |
| busy | output | 1 | Contents are changing |
| rd_en | input | 1 | Host read request |
| rd_row | input | 4 | Host read row |
| rd_col | input | 4 | Host read column |
| rd_data | output | 32 | Entry returned by the host read |
| rd_valid | output | 1 | `rd_data` holds a fresh result |

## Verification
The assertions assume the following about the sender:
- A stalled beat keeps `in_valid` high until it is taken.
- `clear_req` and a new beat are never offered in the same cycle.
- The host waits for `busy` to fall before reading.

The stimulus waits on `in_ready` while holding its beat fixed, and pulses control pins only in cycles with no beat pending. Every tile sweep of reads starts only after `busy` is seen low. Overwrite, accumulate, wraparound, duplicate rows, ignored controls and the clear sweep are each compared against a full 16x16 model of the tile kept in the bench.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam int unsigned TACC_ROWS = 16;
  localparam int unsigned TACC_COLS = 16;
  localparam int unsigned TACC_DW   = 32;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_PASS  = 2'd1,
    CS_SWEEP = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/tacc_ctrl.sv
module tacc_ctrl
  import tacc_pkg::*;
#(
  parameter int unsigned ROWS = TACC_ROWS,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          first_tile,
  input  logic          clear_req,
  input  logic          pipe_v,
  output logic          in_ready,
  output logic          beat_go,
  output logic          beat_ovw,
  output logic          sweep_we,
  output logic [RW-1:0] sweep_row,
  output logic          busy
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  ctrl_state_e   state_q;
  logic          ovw_q;
  logic [RW-1:0] cnt_q;
  logic          clr_go;

  // a clear launches only from a fully idle buffer
  assign clr_go   = clear_req && (state_q == CS_IDLE) && !pipe_v;
  assign in_ready = (state_q != CS_SWEEP) && !clr_go;
  assign beat_go  = in_valid && in_ready;
  assign beat_ovw = ovw_q || (first_tile && (state_q != CS_PASS));
  assign sweep_we  = (state_q == CS_SWEEP);
  assign sweep_row = cnt_q;
  assign busy      = (state_q != CS_IDLE) || pipe_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        CS_IDLE: begin
          if (clr_go) begin
            state_q <= CS_SWEEP;
            cnt_q   <= '0;
          end else if (beat_go && !in_last) begin
            state_q <= CS_PASS;
          end
        end
        CS_PASS: begin
          if (beat_go && in_last) state_q <= CS_IDLE;
        end
        CS_SWEEP: begin
          if (cnt_q == LAST_ROW) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + RW'(1);
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovw_q <= 1'b0;
    end else if (beat_go && in_last) begin
      ovw_q <= 1'b0;
    end else if (first_tile && (state_q != CS_PASS)) begin
      ovw_q <= 1'b1;
    end
  end

  // R4: closing beat disarms overwrite mode
  assert_ovw_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && in_last) |=> !ovw_q);

  // R8: an open pass keeps busy high
  assert_pass_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && !in_last) |=> busy);

  // R7: sweep walks the rows in order, one per cycle
  assert_sweep_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_we && (sweep_row != LAST_ROW)) |=> (sweep_we && (sweep_row == $past(sweep_row) + RW'(1))));

  // R6: a stalled beat stays offered
  assert_hold_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_valid);

  // R10: first_tile inside a pass does not arm overwrite
  assert_ignore_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CS_PASS) && !ovw_q) |=> !ovw_q);
endmodule

// File: rtl/tacc_row_merge.sv
module tacc_row_merge
  import tacc_pkg::*;
#(
  parameter int unsigned COLS = TACC_COLS,
  parameter int unsigned DW   = TACC_DW,
  localparam int unsigned RB  = COLS * DW
) (
  input  logic [RB-1:0] old_row,
  input  logic [RB-1:0] new_row,
  input  logic          ovw,
  output logic [RB-1:0] out_row
);
  // one adder per column; modulo 2^DW, carry out discarded
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DW-1:0] sum_c;
    assign sum_c = old_row[c*DW +: DW] + new_row[c*DW +: DW];
    assign out_row[c*DW +: DW] = ovw ? new_row[c*DW +: DW] : sum_c;
  end
endmodule

// File: rtl/tacc_store.sv
module tacc_store
  import tacc_pkg::*;
#(
  parameter int unsigned ROWS = TACC_ROWS,
  parameter int unsigned COLS = TACC_COLS,
  parameter int unsigned DW   = TACC_DW,
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned CW  = $clog2(COLS),
  localparam int unsigned RB  = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wrow,
  input  logic [RB-1:0] wdata,
  input  logic [RW-1:0] rrow,
  output logic [RB-1:0] rrow_data,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [RB-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wrow] <= wdata;
    end
  end

  assign rrow_data = mem[rrow];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_row][rd_col*DW +: DW];
    end
  end

  // R5: the whole addressed row takes the written value
  assert_row_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(wrow)] == $past(wdata)));

  // R9: read result is flagged one cycle after the request
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/tile_acc_buffer.sv
module tile_acc_buffer
  import tacc_pkg::*;
#(
  parameter int unsigned ROWS = TACC_ROWS,
  parameter int unsigned COLS = TACC_COLS,
  parameter int unsigned DW   = TACC_DW,
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned CW  = $clog2(COLS),
  localparam int unsigned RB  = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [RW-1:0] in_row,
  input  logic          in_last,
  input  logic [RB-1:0] in_data,
  input  logic          first_tile,
  input  logic          clear_req,
  output logic          busy,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic          beat_go, beat_ovw, sweep_we;
  logic [RW-1:0] sweep_row;

  // single stage between the stream and the row write
  logic          pipe_v;
  logic [RW-1:0] pipe_row;
  logic          pipe_ovw;
  logic [RB-1:0] pipe_data;

  logic [RB-1:0] old_row, merged_row, wdata;
  logic [RW-1:0] wrow;
  logic          we;

  tacc_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_last(in_last),
    .first_tile(first_tile), .clear_req(clear_req),
    .pipe_v(pipe_v), .in_ready(in_ready),
    .beat_go(beat_go), .beat_ovw(beat_ovw),
    .sweep_we(sweep_we), .sweep_row(sweep_row), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_v    <= 1'b0;
      pipe_row  <= '0;
      pipe_ovw  <= 1'b0;
      pipe_data <= '0;
    end else begin
      pipe_v <= beat_go;
      if (beat_go) begin
        pipe_row  <= in_row;
        pipe_ovw  <= beat_ovw;
        pipe_data <= in_data;
      end
    end
  end

  tacc_row_merge #(.COLS(COLS), .DW(DW)) u_merge (
    .old_row(old_row), .new_row(pipe_data),
    .ovw(pipe_ovw), .out_row(merged_row)
  );

  assign we    = sweep_we || pipe_v;
  assign wrow  = sweep_we ? sweep_row : pipe_row;
  assign wdata = sweep_we ? '0 : merged_row;

  tacc_store #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(we), .wrow(wrow), .wdata(wdata),
    .rrow(pipe_row), .rrow_data(old_row),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R7: sweep writes and beat writes never collide
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_we && pipe_v));

  // R6: nothing is taken while the sweep owns the store
  assert_no_take_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_we |-> !beat_go);
endmodule

// File: tb/sim_tile_acc_buffer.sv
`timescale 1ns/1ps
module sim_tile_acc_buffer;
  localparam int ROWS = 16;
  localparam int COLS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, first_tile = 1'b0, clear_req = 1'b0, rd_en = 1'b0;
  logic [3:0] in_row = '0, rd_row = '0, rd_col = '0;
  logic [511:0] in_data = '0;
  logic in_ready, busy, rd_valid;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] exp_m [ROWS][COLS];
  logic [511:0] beat_bus;

  always #2.5 clk = ~clk;

  tile_acc_buffer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_last(in_last), .in_data(in_data),
    .first_tile(first_tile), .clear_req(clear_req), .busy(busy),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] val_of(input int pat, input int r, input int c);
    case (pat)
      0: val_of = 32'(r * 1000 + c * 7 + 1);
      1: val_of = 32'(r * r * 11 + c * 13 + 5);
      2: val_of = 32'(r * 77 + c * 19 + 3);
      3: val_of = 32'hFFFF_0000 + 32'(r * 4096 + c);
      4: val_of = 32'(c + 100);
      default: val_of = 32'(r * 31 + c * 5 + 9);
    endcase
  endfunction

  task automatic build(input int pat, input int r);
    for (int c = 0; c < COLS; c++) beat_bus[c*32 +: 32] = val_of(pat, r, c);
  endtask

  task automatic model(input int r, input bit ovw);
    for (int c = 0; c < COLS; c++)
      exp_m[r][c] = ovw ? beat_bus[c*32 +: 32] : exp_m[r][c] + beat_bus[c*32 +: 32];
  endtask

  // offers beat_bus, waits for acceptance; returns at the negedge after the take edge
  task automatic send(input int r, input bit last, input bit ovw);
    @(negedge clk);
    in_valid = 1'b1; in_row = 4'(r); in_last = last; in_data = beat_bus;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    model(r, ovw);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_first();
    @(negedge clk); first_tile = 1'b1;
    @(negedge clk); first_tile = 1'b0;
  endtask

  task automatic readall(input string tag);
    while (busy) @(negedge clk);
    for (int i = 0; i <= ROWS * COLS; i++) begin
      @(negedge clk);
      if (i > 0) chk(rd_valid && (rd_data == exp_m[(i-1)/COLS][(i-1)%COLS]), tag, rd_data,
                     exp_m[(i-1)/COLS][(i-1)%COLS]);
      if (i < ROWS * COLS) begin
        rd_en = 1'b1; rd_row = 4'(i / COLS); rd_col = 4'(i % COLS);
      end else rd_en = 1'b0;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  initial begin
    int cnt;
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) exp_m[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", 32'(busy), 0);
    chk(in_ready, "R1 in_ready", 32'(in_ready), 1);
    chk(!rd_valid, "R1 rd_valid", 32'(rd_valid), 0);
    readall("R1 zero tile");

    // R2 overwrite pass, rows ascending
    pulse_first();
    for (int r = 0; r < ROWS; r++) begin build(0, r); send(r, r == ROWS - 1, 1'b1); end
    readall("R2 overwrite");

    // R3 R4 accumulate pass, rows descending; busy timing R8
    for (int r = ROWS - 1; r >= 0; r--) begin
      build(1, r); send(r, r == 0, 1'b0);
      if (r == 8) begin
        chk(busy, "R8 busy in pass", 32'(busy), 1);
        chk(in_ready, "R6 ready in pass", 32'(in_ready), 1);
      end
    end
    chk(busy, "R8 busy on final write", 32'(busy), 1);
    @(negedge clk);
    chk(!busy, "R8 idle after pass", 32'(busy), 0);
    readall("R3 R4 accumulate");

    // R10 ignored controls inside a pass, duplicate rows R5
    build(2, 3); send(3, 1'b0, 1'b0);
    pulse_first();
    @(negedge clk); clear_req = 1'b1;
    @(negedge clk); clear_req = 1'b0;
    chk(busy && in_ready, "R10 no sweep in pass", {30'd0, busy, in_ready}, 32'd3);
    build(5, 3); send(3, 1'b0, 1'b0);
    build(2, 7); send(7, 1'b0, 1'b0);
    build(5, 7); send(7, 1'b1, 1'b0);
    readall("R10 R5 ignored controls");

    // R3 wraparound modulo 2^32
    for (int r = 0; r < ROWS; r++) begin build(3, r); send(r, r == ROWS - 1, 1'b0); end
    readall("R3 wrap");
    for (int r = 0; r < ROWS; r++) begin build(3, r); send(r, r == ROWS - 1, 1'b0); end
    readall("R3 wrap twice");

    // R2 R5 single-beat overwrite of one row
    pulse_first();
    build(4, 5); send(5, 1'b1, 1'b1);
    readall("R5 single row overwrite");

    // R7 clear sweep with a beat held under back-pressure R6
    @(negedge clk); clear_req = 1'b1;
    @(negedge clk); clear_req = 1'b0;
    chk(busy, "R7 busy in sweep", 32'(busy), 1);
    chk(!in_ready, "R6 ready low in sweep", 32'(in_ready), 0);
    build(6, 9);
    in_valid = 1'b1; in_row = 4'd9; in_last = 1'b1; in_data = beat_bus;
    cnt = 0;
    while (!in_ready) begin cnt++; @(negedge clk); end
    chk(cnt == ROWS, "R7 sweep length", 32'(cnt), 32'(ROWS));
    @(posedge clk);
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) exp_m[r][c] = '0;
    model(9, 1'b0);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    readall("R7 R6 cleared tile");

    // R9 single read latency
    @(negedge clk); rd_en = 1'b1; rd_row = 4'd9; rd_col = 4'd4;
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid && rd_data == exp_m[9][4], "R9 read latency", rd_data, exp_m[9][4]);
    @(negedge clk);
    chk(!rd_valid, "R9 valid drops", 32'(rd_valid), 0);

    finish_up();
  end
endmodule